// File: doc/BRIEF.md
# Pager Preamble Detector with Glitch-Rate Monitor

This block watches an already synchronized NRZ pager line and tells a receiver controller when the alternating 1,0 preamble is present. An oversampling tick (sixteen per bit) and a bit-time strobe come from an external clock-recovery stage. Each bit decision is taken from the middle sample of the bit. Pulse-width distortion that keeps each mark centred on its bit is therefore tolerated. Mark widths from 25% to 75% of the two-bit 1,0 cycle are accepted.

In hunting mode the block runs a 544-bit watch window and counts glitches. A glitch is a rising edge that comes within one bit time of the previous rising edge. When the glitch count reaches a programmed limit, the block reports a rate error. When the window runs out with no preamble and no rate error, it reports a timeout. In idle mode the block only looks for a short six-bit alternating run, which lets the receiver return quickly from battery saving. All three results are single-cycle registered pulses.

Top module: `preamble_hunter`

## Requirements
- R1: `rst` is synchronous and active high. While it is asserted and after it is released, all three outputs are low. Reset clears every internal count, including a partial alternating run.
- R2: `mode_i` = 2'b10 is hunting mode. In this mode `preamble_o` pulses when eight consecutive bit decisions each differ from the one before. The run then starts from zero, so a continuous preamble gives one pulse every eight bits. Any repeated bit value restarts the run.
- R3: A bit period begins at a `bit_strobe_i` cycle. The decision for the bit is the line value on the ninth `sample_tick_i` after that strobe (tick index 8 of 0..15). The decision is evaluated at the next strobe. Alternating marks whose width lies between 25% and 75% of the two-bit cycle, centred on the bit centres, are decided correctly.
- R4: `mode_i` = 2'b01 is idle mode. In this mode `preamble_o` pulses when the newest six decisions read 101010 or 010101 and at least six decisions have been taken since the last detection or since idle mode was entered.
- R5: In hunting mode, a rising edge of the polarity-corrected line that arrives fewer than 16 ticks after the previous rising edge counts as one error. Errors are not counted in idle mode.
- R6: `rate_err_o` pulses when the error count reaches `err_limit_i`+1 (0 means 1 error, 7 means 8 errors). The pulse clears the count and restarts the window.
- R7: A preamble detection in hunting mode clears the error count.
- R8: In hunting mode, `timeout_o` pulses on the 544th bit strobe after mode entry or after the last window restart. The window restarts on a preamble detection, on a rate error and after each timeout. There is no timeout in idle mode.
- R9: `invert_i` = 1 inverts the line before both the bit decisions and the rising-edge detection.
- R10: `mode_i` = 2'b00 (and 2'b11) is off. When off, the block produces no outputs. Any change of `mode_i` clears all internal state.
- R11: Each output pulse is registered and appears in the cycle after the strobe or tick that triggered it. At most one output is high in any cycle. `timeout_o` and `rate_err_o` only follow hunting-mode cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Synchronized NRZ data line |
| sample_tick_i | input | 1 | Oversampling tick, 16 per bit |
| bit_strobe_i | input | 1 | Bit-boundary strobe; closes one bit and opens the next |
| mode_i | input | 2 | 00 off, 01 idle, 10 hunting, 11 off |
| err_limit_i | input | 3 | Error limit minus one |
| invert_i | input | 1 | Line polarity inversion |
| preamble_o | output | 1 | Preamble detected pulse |
| rate_err_o | output | 1 | Rate error pulse |
| timeout_o | output | 1 | Watch window expired pulse |

## Verification
The assertions check the following on every cycle:
- The three result pulses never overlap.
- Each pulse traces back to the kind of input event that can cause it: a strobe for a detection or a timeout, a tick for a rate error.
- Timeouts and rate errors only follow hunting-mode cycles.
- Nothing is produced while the block is off.

Only the bench scenarios can show the counting behaviour. This covers the exact bit on which eight alternations or a six-bit idle pattern fire, the decision under 25% and 75% mark widths, the error limit being reached on exactly the limit-th glitch, a preamble clearing the error count, the 544-bit window and its restart, and the direction of edge detection under polarity inversion.

// File: rtl/pd_pkg.sv
package pd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        PD_OFF  = 2'b00,
        PD_IDLE = 2'b01,
        PD_HUNT = 2'b10,
        PD_RSV  = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic pre;
        logic rate;
        logic tmo;
    } pd_evt_t;

    function automatic logic pd_live(input pd_mode_e m);
        return (m == PD_IDLE) || (m == PD_HUNT);
    endfunction
endpackage

// File: rtl/pd_sampler.sv
// Mid-bit decision and close-rising-edge (glitch) detection.
module pd_sampler #(
    parameter int SPB = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic line_i,
    input  logic inv_i,
    input  logic tick_i,
    input  logic strobe_i,
    output logic dec_o,
    output logic err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW = $clog2(SPB + 1);
    localparam logic [PW-1:0] MID  = PW'(SPB / 2);
    localparam logic [PW-1:0] LAST = PW'(SPB - 1);
    localparam logic [PW-1:0] SAT  = PW'(SPB);

    logic [PW-1:0] phase_q, since_q;
    logic          dec_q, prev_q, primed_q;
    logic          cur, rise;

    assign cur   = line_i ^ inv_i;
    assign rise  = tick_i && primed_q && cur && !prev_q;
    assign err_o = rise && (since_q < LAST);
    assign dec_o = dec_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q  <= '0;
            since_q  <= LAST;
            dec_q    <= 1'b0;
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            if (strobe_i)
                phase_q <= '0;
            else if (tick_i && phase_q != SAT)
                phase_q <= phase_q + PW'(1);

            if (tick_i && !strobe_i && phase_q == MID)
                dec_q <= cur;

            if (tick_i) begin
                prev_q   <= cur;
                primed_q <= 1'b1;
                if (rise)
                    since_q <= '0;
                else if (since_q != LAST)
                    since_q <= since_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/pd_pattern.sv
// Alternating-run tracker (hunting) and six-bit history match (idle).
module pd_pattern
    import pd_pkg::*;
#(
    parameter int RUN_BITS  = 8,
    parameter int IDLE_BITS = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  pd_mode_e mode_i,
    input  logic     strobe_i,
    input  logic     dec_i,
    output logic     hit_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int RW = $clog2(RUN_BITS + 1);
    localparam int VW = $clog2(IDLE_BITS + 1);

    logic                 have_q, last_q;
    logic [RW-1:0]        run_q, run_nx;
    logic [IDLE_BITS-1:0] hist_q, hist_nx;
    logic [VW-1:0]        valid_q, valid_nx;
    logic                 run_hit, idle_hit, alt_all;

    always_comb begin
        run_nx   = (have_q && dec_i != last_q) ? run_q + RW'(1) : RW'(1);
        hist_nx  = {hist_q[IDLE_BITS-2:0], dec_i};
        valid_nx = (valid_q == VW'(IDLE_BITS)) ? valid_q : valid_q + VW'(1);
        alt_all  = &(hist_nx[IDLE_BITS-1:1] ^ hist_nx[IDLE_BITS-2:0]);
        run_hit  = strobe_i && (mode_i == PD_HUNT) && (run_nx == RW'(RUN_BITS));
        idle_hit = strobe_i && (mode_i == PD_IDLE) && (valid_nx == VW'(IDLE_BITS)) && alt_all;
    end

    assign hit_o = run_hit || idle_hit;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            have_q  <= 1'b0;
            last_q  <= 1'b0;
            run_q   <= '0;
            hist_q  <= '0;
            valid_q <= '0;
        end else if (strobe_i) begin
            have_q  <= 1'b1;
            last_q  <= dec_i;
            run_q   <= run_hit ? '0 : run_nx;
            hist_q  <= hist_nx;
            valid_q <= idle_hit ? '0 : valid_nx;
        end
    end
endmodule

// File: rtl/pd_window.sv
// Error counter against the programmed limit and the bit-count watch window.
module pd_window #(
    parameter int WIN_BITS = 544,
    parameter int THR_W    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             strobe_i,
    input  logic             err_i,
    input  logic             pre_i,
    input  logic [THR_W-1:0] lim_i,
    output logic             rate_o,
    output logic             tmo_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WW = $clog2(WIN_BITS + 1);
    localparam int CW = THR_W + 1;

    logic [WW-1:0] win_q, win_nx;
    logic [CW-1:0] cnt_q, cnt_nx, limit;

    assign limit = CW'(lim_i) + CW'(1);

    always_comb begin
        win_nx = '0;
        cnt_nx = '0;
        rate_o = 1'b0;
        tmo_o  = 1'b0;
        if (active_i && !pre_i) begin
            win_nx = win_q;
            cnt_nx = cnt_q;
            if (err_i) begin
                if (cnt_q + CW'(1) == limit) begin
                    rate_o = 1'b1;
                    cnt_nx = '0;
                    win_nx = '0;
                end else begin
                    cnt_nx = cnt_q + CW'(1);
                end
            end
            if (strobe_i && !rate_o) begin
                if (win_q == WW'(WIN_BITS - 1)) begin
                    tmo_o  = 1'b1;
                    win_nx = '0;
                end else begin
                    win_nx = win_q + WW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            cnt_q <= '0;
        end else begin
            win_q <= win_nx;
            cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/preamble_hunter.sv
module preamble_hunter
    import pd_pkg::*;
#(
    parameter int SPB       = 16,
    parameter int WIN_BITS  = 544,
    parameter int RUN_BITS  = 8,
    parameter int IDLE_BITS = 6,
    parameter int THR_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             sample_tick_i,
    input  logic             bit_strobe_i,
    input  logic [1:0]       mode_i,
    input  logic [THR_W-1:0] err_limit_i,
    input  logic             invert_i,
    output logic             preamble_o,
    output logic             rate_err_o,
    output logic             timeout_o
);
    timeunit 1ns;
    timeprecision 1ps;

    pd_mode_e mode_e, mode_q;
    logic     clr, live, hunting;
    logic     dec, err, hit, rate, tmo;
    pd_evt_t  evt_d, evt_q;

    assign mode_e  = pd_mode_e'(mode_i);
    assign clr     = (mode_e != mode_q) || !pd_live(mode_e);
    assign live    = !clr;
    assign hunting = live && (mode_e == PD_HUNT);

    pd_sampler #(.SPB(SPB)) u_smp (
        .clk(clk), .rst(rst), .clr(clr), .line_i(line_i), .inv_i(invert_i),
        .tick_i(sample_tick_i), .strobe_i(bit_strobe_i), .dec_o(dec), .err_o(err)
    );

    pd_pattern #(.RUN_BITS(RUN_BITS), .IDLE_BITS(IDLE_BITS)) u_pat (
        .clk(clk), .rst(rst), .clr(clr), .mode_i(mode_e),
        .strobe_i(bit_strobe_i), .dec_i(dec), .hit_o(hit)
    );

    pd_window #(.WIN_BITS(WIN_BITS), .THR_W(THR_W)) u_win (
        .clk(clk), .rst(rst), .active_i(hunting), .strobe_i(bit_strobe_i),
        .err_i(err), .pre_i(hit), .lim_i(err_limit_i), .rate_o(rate), .tmo_o(tmo)
    );

    always_comb begin
        evt_d.pre  = live && hit;
        evt_d.rate = hunting && rate;
        evt_d.tmo  = hunting && tmo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PD_OFF;
            evt_q  <= '0;
        end else begin
            mode_q <= mode_e;
            evt_q  <= evt_d;
        end
    end

    assign preamble_o = evt_q.pre;
    assign rate_err_o = evt_q.rate;
    assign timeout_o  = evt_q.tmo;
endmodule

// File: rtl/preamble_hunter_chk.sv
module preamble_hunter_chk (
    input logic       clk,
    input logic       rst,
    input logic       sample_tick_i,
    input logic       bit_strobe_i,
    input logic [1:0] mode_i,
    input logic       preamble_o,
    input logic       rate_err_o,
    input logic       timeout_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({preamble_o, rate_err_o, timeout_o}) <= 1);

    // R2 R4
    pre_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        preamble_o |-> $past(bit_strobe_i));

    // R8
    tmo_source_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> ($past(bit_strobe_i) && $past(mode_i) == 2'b10));

    // R6
    rate_source_chk: assert property (@(posedge clk) disable iff (rst)
        rate_err_o |-> ($past(sample_tick_i) && $past(mode_i) == 2'b10));

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_i) == 2'b00) |-> !(preamble_o || rate_err_o || timeout_o));
endmodule

bind preamble_hunter preamble_hunter_chk u_chk (
    .clk(clk), .rst(rst), .sample_tick_i(sample_tick_i), .bit_strobe_i(bit_strobe_i),
    .mode_i(mode_i), .preamble_o(preamble_o), .rate_err_o(rate_err_o), .timeout_o(timeout_o)
);

// File: tb/preamble_hunter_tb.sv
module preamble_hunter_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0, rst = 1'b1, line = 1'b0, tick = 1'b0, strobe = 1'b0, inv = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [2:0] lim = 3'd0;
    logic       pre, rate, tmo;

    always #2.5 clk = ~clk;

    preamble_hunter u_dut (
        .clk(clk), .rst(rst), .line_i(line), .sample_tick_i(tick), .bit_strobe_i(strobe),
        .mode_i(mode), .err_limit_i(lim), .invert_i(inv),
        .preamble_o(pre), .rate_err_o(rate), .timeout_o(tmo)
    );

    int n_pre = 0, n_rate = 0, n_tmo = 0;
    int b_pre = 0, b_rate = 0, b_tmo = 0;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always @(negedge clk) if (!rst) begin
        if (pre)  n_pre++;
        if (rate) n_rate++;
        if (tmo)  n_tmo++;
    end

    typedef struct packed {
        logic [1:0]  mode;
        logic        inv;
        logic [3:0]  req;
        logic [4:0]  nbits;
        logic [15:0] bits;
        logic [5:0]  width;
        logic [2:0]  exp_pre;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b0, 4'd2,  5'd8,  16'h0055, 6'd16, 3'd1}, // R2 eight alternating
        '{2'b10, 1'b0, 4'd2,  5'd7,  16'h0055, 6'd16, 3'd0}, // R2 seven only
        '{2'b10, 1'b0, 4'd2,  5'd16, 16'h5555, 6'd16, 3'd2}, // R2 run restarts
        '{2'b10, 1'b0, 4'd2,  5'd8,  16'h00AD, 6'd16, 3'd0}, // R2 broken run
        '{2'b10, 1'b0, 4'd3,  5'd8,  16'h0055, 6'd8,  3'd1}, // R3 25% mark
        '{2'b10, 1'b0, 4'd3,  5'd8,  16'h0055, 6'd24, 3'd1}, // R3 75% mark
        '{2'b10, 1'b1, 4'd9,  5'd8,  16'h0055, 6'd16, 3'd1}, // R9 inverted line
        '{2'b01, 1'b0, 4'd4,  5'd6,  16'h0015, 6'd16, 3'd1}, // R4 six alternating
        '{2'b01, 1'b0, 4'd4,  5'd5,  16'h0015, 6'd16, 3'd0}, // R4 five only
        '{2'b01, 1'b0, 4'd4,  5'd7,  16'h002B, 6'd24, 3'd1}, // R4 after a repeat
        '{2'b01, 1'b0, 4'd4,  5'd12, 16'h0555, 6'd16, 3'd2}, // R4 history restarts
        '{2'b00, 1'b0, 4'd10, 5'd16, 16'h5555, 6'd16, 3'd0}  // R10 off
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic snap();
        b_pre = n_pre; b_rate = n_rate; b_tmo = n_tmo;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic tk(input logic v);
        @(negedge clk); line = v; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic strb();
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic bare(input int n);
        for (int i = 0; i < n; i++) strb();
    endtask

    function automatic bit inw(input int x, input int w);
        return (x >= 8 - w / 2) && (x < 8 + w / 2);
    endfunction

    function automatic bit lvl(input logic [15:0] b, input int n, input int i, input int p, input int w);
        bit r = 1'b0;
        if (i < n && b[i] && inw(p, w)) r = 1'b1;
        if (i > 0 && b[i-1] && inw(p + 16, w)) r = 1'b1;
        if (i + 1 < n && b[i+1] && inw(p - 16, w)) r = 1'b1;
        return r;
    endfunction

    task automatic send_bits(input logic [15:0] b, input int n, input int w);
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 16; p++) tk(lvl(b, n, i, p, w) ^ inv);
            strb();
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode = 2'b00;
        repeat (2) @(negedge clk);
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic gap();
        for (int i = 0; i < 20; i++) tk(1'b0);
    endtask

    task automatic glitch(input int n);
        for (int i = 0; i < n; i++) begin
            tk(1'b1); tk(1'b0); tk(1'b0); tk(1'b0);
        end
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        wrap_up();
    end

    initial begin
        vec_t v;
        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1", "pre in reset", int'(pre), 0);
        chk("R1", "rate in reset", int'(rate), 0);
        rst = 1'b0;
        settle();
        chk("R1", "outputs after reset", int'(pre | rate | tmo), 0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            inv = v.inv;
            lim = 3'd0;
            set_mode(v.mode);
            snap();
            send_bits(v.bits, int'(v.nbits), int'(v.width));
            settle();
            chk($sformatf("R%0d vec%0d", v.req, k), "preamble", n_pre - b_pre, int'(v.exp_pre));
            chk($sformatf("R%0d vec%0d", v.req, k), "rate_err", n_rate - b_rate, 0);
            chk($sformatf("R%0d vec%0d", v.req, k), "timeout", n_tmo - b_tmo, 0);
        end
        inv = 1'b0;

        // R6 limit 3 errors, repeats after clearing
        lim = 3'd2; set_mode(2'b10); snap();
        gap(); glitch(3); settle();
        chk("R6", "two errors limit3", n_rate - b_rate, 0);
        glitch(1); settle();
        chk("R6", "third error limit3", n_rate - b_rate, 1);
        glitch(3); settle();
        chk("R6", "count cleared after rate error", n_rate - b_rate, 2);

        // R6 limit 8 errors; R5 rising-edge spacing
        lim = 3'd7; set_mode(2'b10); snap();
        gap(); glitch(8); settle();
        chk("R5", "seven errors limit8", n_rate - b_rate, 0);
        glitch(1); settle();
        chk("R6", "eighth error limit8", n_rate - b_rate, 1);

        // R7 preamble clears the error count
        lim = 3'd2; set_mode(2'b10); snap();
        gap(); glitch(3); gap(); strb();
        send_bits(16'h00AB, 9, 16); gap();
        glitch(3); settle();
        chk("R7", "preamble seen", n_pre - b_pre, 1);
        chk("R7", "count cleared by preamble", n_rate - b_rate, 0);
        glitch(1); settle();
        chk("R7", "third error after clear", n_rate - b_rate, 1);

        // R8 window timeout and restart after timeout
        lim = 3'd0; set_mode(2'b10); snap();
        bare(543); settle();
        chk("R8", "543 strobes", n_tmo - b_tmo, 0);
        bare(1); settle();
        chk("R8", "544th strobe", n_tmo - b_tmo, 1);
        bare(544); settle();
        chk("R8", "second window", n_tmo - b_tmo, 2);

        // R8 preamble restarts the window
        set_mode(2'b10); snap();
        bare(530); send_bits(16'h00AB, 9, 16);
        bare(543); settle();
        chk("R8", "preamble restart", n_pre - b_pre, 1);
        chk("R8", "no timeout after restart", n_tmo - b_tmo, 0);
        bare(1); settle();
        chk("R8", "timeout 544 after restart", n_tmo - b_tmo, 1);

        // R9 polarity decides which edges count
        lim = 3'd0;
        for (int pol = 0; pol < 2; pol++) begin
            inv = pol[0];
            set_mode(2'b10); snap();
            for (int i = 0; i < 4; i++) tk(1'b0);
            for (int t = 0; t < 42; t++) tk((t < 10) || (t == 20) || (t == 21));
            settle();
            chk("R9", $sformatf("falls close, inv=%0d", pol), n_rate - b_rate, pol);
        end
        inv = 1'b0;

        // R5 R8 idle mode ignores errors and has no window
        set_mode(2'b01); snap();
        gap(); glitch(4); bare(600); settle();
        chk("R5", "idle glitches", n_rate - b_rate, 0);
        chk("R8", "idle no timeout", n_tmo - b_tmo, 0);

        // R1 reset mid-run discards a partial run
        set_mode(2'b10); snap();
        send_bits(16'h0055, 7, 16);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        send_bits(16'h0000, 1, 16); settle();
        chk("R1", "run cleared by reset", n_pre - b_pre, 0);

        // R10 mode change clears a partial run
        set_mode(2'b10); snap();
        send_bits(16'h0055, 7, 16);
        @(negedge clk); mode = 2'b01;
        repeat (2) @(negedge clk); mode = 2'b10;
        repeat (2) @(negedge clk);
        send_bits(16'h0000, 1, 16); settle();
        chk("R10", "run cleared by mode change", n_pre - b_pre, 0);

        wrap_up();
    end
endmodule